// File: doc/BRIEF.md
# Packed Lane Width Converter

This unit changes the lane width of packed data held in two 64-bit operands. In the narrowing direction it halves every lane of both operands and clamps each value into the narrower lane. The clamp is signed for word-to-byte and doubleword-to-word, and unsigned for word-to-byte only. The narrowed lanes of operand A fill the low half of the result and those of operand B fill the high half.

In the widening direction it interleaves lanes taken from one half of both operands. It works at byte, word or doubleword granularity. This suits a later stage that needs wider elements, or that needs to merge two streams.

A request is a one-cycle valid strobe with an opcode, a size and the two operands. The answer appears one clock later with its own valid strobe. An opcode and size pair that is not supported produces a zero result and raises an error flag.

Top module: `pack_unpack_unit`

## Requirements
- R1: The result, the error flag and `valid_o` are registered. `valid_o` is high exactly in the cycle after a cycle in which `valid_i` is high, and low otherwise.
- R2: Opcode 0 with size 1 clamps each 16-bit lane to a signed byte. Values above 127 give 0x7F, values below -128 give 0x80, and other values give their low byte. Lane i of A goes to byte i of the result and lane i of B goes to byte 4+i.
- R3: Opcode 0 with size 2 clamps each 32-bit lane to a signed word. Values above 32767 give 0x7FFF, values below -32768 give 0x8000, and other values give their low word. Lane i of A goes to word i and lane i of B goes to word 2+i.
- R4: Opcode 1 with size 1 clamps each 16-bit lane, read as signed, to an unsigned byte. Negative values give 0x00, values above 255 give 0xFF, and other values give their low byte. Lanes are placed as in R2.
- R5: Opcode 2 interleaves the lanes of the lower half of both operands. The lane is 8, 16 or 32 bits for size 0, 1 or 2. Result lane 2k is A lane k and result lane 2k+1 is B lane k.
- R6: Opcode 3 interleaves the upper half in the same way. Result lane 2k is A lane n/2+k and result lane 2k+1 is B lane n/2+k, where n is the number of lanes per operand.
- R7: The following combinations give a zero result with `err_o` high in the output cycle: opcode 0 with size 0 or 3, opcode 1 with any size other than 1, and opcodes 2 or 3 with size 3. Every supported combination gives `err_o` low.
- R8: While `valid_i` is low, `result_o` and `err_o` keep their last values, whatever the operands do.
- R9: After reset, `valid_o`, `err_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 signed pack, 1 unsigned pack, 2 low unpack, 3 high unpack |
| size_i | input | 2 | Lane width: 0 byte, 1 word, 2 doubleword, 3 reserved (for pack, the source width) |
| a_i | input | 64 | Operand A (destination operand) |
| b_i | input | 64 | Operand B (source operand) |
| valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Converted data |
| err_o | output | 1 | Unsupported combination |

## Verification
Every result, error flag and valid strobe is due exactly one clock after the cycle that holds the request. The bench drives each request on a falling edge and keeps it for a single cycle. It compares all three outputs at the next falling edge, half a period after the capturing rising edge. It then leaves the inputs idle for one cycle with new operand values and confirms, at the next falling edge, that the strobe is low and that the result and flag have not moved.

// File: rtl/pku_pkg.sv
package pku_pkg;
  typedef enum logic [1:0] {
    OP_PACK_SS = 2'd0,
    OP_PACK_US = 2'd1,
    OP_UNPK_LO = 2'd2,
    OP_UNPK_HI = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_W   = 2'd1,
    SZ_D   = 2'd2,
    SZ_RSV = 2'd3
  } size_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned DWRD_W = 32;
endpackage

// File: rtl/pku_sat.sv
module pku_sat #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 8,
  parameter bit          UNS   = 1'b0
) (
  input  logic [IN_W-1:0]  din_i,
  output logic [OUT_W-1:0] dout_o
);
  localparam int unsigned EXT_W = IN_W - OUT_W + 1;

  generate
    if (UNS) begin : g_uns
      logic over;
      assign over = |din_i[IN_W-2:OUT_W];
      always_comb begin
        if (din_i[IN_W-1])  dout_o = '0;
        else if (over)      dout_o = '1;
        else                dout_o = din_i[OUT_W-1:0];
      end
    end else begin : g_sgn
      logic fits;
      assign fits = (din_i[IN_W-1:OUT_W-1] == {EXT_W{din_i[IN_W-1]}});
      always_comb begin
        if (fits)                dout_o = din_i[OUT_W-1:0];
        else if (din_i[IN_W-1])  dout_o = {1'b1, {(OUT_W-1){1'b0}}};
        else                     dout_o = {1'b0, {(OUT_W-1){1'b1}}};
      end
    end
  endgenerate
endmodule

// File: rtl/pku_pack.sv
module pku_pack #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IN_W   = 16,
  parameter bit          UNS    = 1'b0
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned OUT_W = IN_W / 2;
  localparam int unsigned NL    = DATA_W / IN_W;

  generate
    for (genvar i = 0; i < NL; i++) begin : g_lane
      // A lanes fill the low half, B lanes the high half
      pku_sat #(.IN_W(IN_W), .OUT_W(OUT_W), .UNS(UNS)) u_sat_a (
        .din_i (a_i[i*IN_W +: IN_W]),
        .dout_o(res_o[i*OUT_W +: OUT_W])
      );
      pku_sat #(.IN_W(IN_W), .OUT_W(OUT_W), .UNS(UNS)) u_sat_b (
        .din_i (b_i[i*IN_W +: IN_W]),
        .dout_o(res_o[(NL+i)*OUT_W +: OUT_W])
      );
    end
  endgenerate
endmodule

// File: rtl/pku_unpack.sv
module pku_unpack #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic              hi_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned NL     = DATA_W / LANE_W;
  localparam int unsigned HALF   = NL / 2;
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] a_h, b_h;
  assign a_h = hi_i ? a_i[DATA_W-1:HALF_W] : a_i[HALF_W-1:0];
  assign b_h = hi_i ? b_i[DATA_W-1:HALF_W] : b_i[HALF_W-1:0];

  generate
    for (genvar k = 0; k < HALF; k++) begin : g_pair
      assign res_o[(2*k)*LANE_W   +: LANE_W] = a_h[k*LANE_W +: LANE_W];
      assign res_o[(2*k+1)*LANE_W +: LANE_W] = b_h[k*LANE_W +: LANE_W];
    end
  endgenerate
endmodule

// File: rtl/pack_unpack_unit.sv
module pack_unpack_unit
  import pku_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              err_o
);
  op_e   op;
  size_e sz;
  assign op = op_e'(op_i);
  assign sz = size_e'(size_i);

  logic [DATA_W-1:0] ss_w, ss_d, us_w, up_b, up_w, up_d;
  logic              hi;
  assign hi = (op == OP_UNPK_HI);

  pku_pack #(.DATA_W(DATA_W), .IN_W(WORD_W), .UNS(1'b0)) u_ss_w (.a_i(a_i), .b_i(b_i), .res_o(ss_w));
  pku_pack #(.DATA_W(DATA_W), .IN_W(DWRD_W), .UNS(1'b0)) u_ss_d (.a_i(a_i), .b_i(b_i), .res_o(ss_d));
  pku_pack #(.DATA_W(DATA_W), .IN_W(WORD_W), .UNS(1'b1)) u_us_w (.a_i(a_i), .b_i(b_i), .res_o(us_w));

  pku_unpack #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_up_b (.hi_i(hi), .a_i(a_i), .b_i(b_i), .res_o(up_b));
  pku_unpack #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_up_w (.hi_i(hi), .a_i(a_i), .b_i(b_i), .res_o(up_w));
  pku_unpack #(.DATA_W(DATA_W), .LANE_W(DWRD_W)) u_up_d (.hi_i(hi), .a_i(a_i), .b_i(b_i), .res_o(up_d));

  logic [DATA_W-1:0] res_d;
  logic              err_d;

  always_comb begin
    res_d = '0;
    err_d = 1'b0;
    unique case (op)
      OP_PACK_SS: begin
        if (sz == SZ_W)      res_d = ss_w;
        else if (sz == SZ_D) res_d = ss_d;
        else                 err_d = 1'b1;
      end
      OP_PACK_US: begin
        if (sz == SZ_W) res_d = us_w;
        else            err_d = 1'b1;
      end
      OP_UNPK_LO, OP_UNPK_HI: begin
        unique case (sz)
          SZ_B:    res_d = up_b;
          SZ_W:    res_d = up_w;
          SZ_D:    res_d = up_d;
          default: err_d = 1'b1;
        endcase
      end
      default: err_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        err_o    <= err_d;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_SS_CLAMP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && size_i == 2'd1 && !a_i[15] && |a_i[14:7])
    |=> result_o[7:0] == 8'h7f); // R2
  AST_US_NEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && size_i == 2'd1 && a_i[15])
    |=> result_o[7:0] == 8'h00); // R4
  AST_UNPK_LO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2 && size_i == 2'd0)
    |=> (result_o[7:0] == $past(a_i[7:0]) && result_o[15:8] == $past(b_i[7:0]))); // R5
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> result_o == '0); // R7
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(err_o))); // R8
endmodule

// File: tb/tb_pack_unpack_unit.sv
`timescale 1ns/1ps
module tb_pack_unpack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0, size_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o, err_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pack_unpack_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
  );

  function automatic logic [15:0] clamp_s(longint v, int w);
    longint hi = (longint'(1) <<< (w-1)) - 1;
    longint lo = -(longint'(1) <<< (w-1));
    longint t = (v > hi) ? hi : ((v < lo) ? lo : v);
    return t[15:0];
  endfunction

  function automatic logic [7:0] clamp_u(longint v);
    longint t = (v < 0) ? 0 : ((v > 255) ? 255 : v);
    return t[7:0];
  endfunction

  function automatic bit is_bad(logic [1:0] op, logic [1:0] sz);
    case (op)
      2'd0: return !(sz == 2'd1 || sz == 2'd2);
      2'd1: return sz != 2'd1;
      default: return sz == 2'd3;
    endcase
  endfunction

  function automatic logic [63:0] model(logic [1:0] op, logic [1:0] sz, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    logic [15:0] t;
    if (is_bad(op, sz)) return '0;
    if (op == 2'd0 && sz == 2'd1) begin
      for (int i = 0; i < 4; i++) begin
        t = clamp_s(longint'($signed(a[i*16 +: 16])), 8); r[i*8 +: 8] = t[7:0];
        t = clamp_s(longint'($signed(b[i*16 +: 16])), 8); r[32+i*8 +: 8] = t[7:0];
      end
    end else if (op == 2'd0) begin
      for (int i = 0; i < 2; i++) begin
        r[i*16 +: 16]    = clamp_s(longint'($signed(a[i*32 +: 32])), 16);
        r[32+i*16 +: 16] = clamp_s(longint'($signed(b[i*32 +: 32])), 16);
      end
    end else if (op == 2'd1) begin
      for (int i = 0; i < 4; i++) begin
        r[i*8 +: 8]    = clamp_u(longint'($signed(a[i*16 +: 16])));
        r[32+i*8 +: 8] = clamp_u(longint'($signed(b[i*16 +: 16])));
      end
    end else begin
      int lw = 8 << sz;
      int half = (64 / lw) / 2;
      int base = (op == 2'd3) ? half : 0;
      for (int k = 0; k < half; k++)
        for (int j = 0; j < lw; j++) begin
          r[2*k*lw + j]     = a[(base+k)*lw + j];
          r[(2*k+1)*lw + j] = b[(base+k)*lw + j];
        end
    end
    return r;
  endfunction

  function automatic string req_of(logic [1:0] op, logic [1:0] sz);
    if (is_bad(op, sz)) return "R7";
    case (op)
      2'd0: return (sz == 2'd2) ? "R3" : "R2";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request, then one idle cycle to confirm hold behaviour
  task automatic run_op(logic [1:0] op, logic [1:0] sz, logic [63:0] a, logic [63:0] b);
    logic [63:0] exp = model(op, sz, a, b);
    logic        bad = is_bad(op, sz);
    valid_i = 1'b1; op_i = op; size_i = sz; a_i = a; b_i = b;
    @(negedge clk);
    valid_i = 1'b0;
    a_i = {$urandom, $urandom}; b_i = {$urandom, $urandom};
    op_i = 2'($urandom); size_i = 2'($urandom);
    check("R1", {63'd0, valid_o}, 64'd1);
    check(req_of(op, sz), result_o, exp);
    check(bad ? "R7" : req_of(op, sz), {63'd0, err_o}, {63'd0, bad});
    @(negedge clk);
    check("R1", {63'd0, valid_o}, 64'd0);
    check("R8", result_o, exp);
    check("R8", {63'd0, err_o}, {63'd0, bad});
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R9", result_o, 64'd0);
    check("R9", {62'd0, valid_o, err_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {62'd0, valid_o, err_o}, 64'd0);

    // R2 directed: 128 -> 7F, -129 -> 80, 127 stays, -128 stays
    run_op(2'd0, 2'd1, 64'h8000_FF80_FF7F_0080, 64'h0001_7FFF_FFFF_007F);
    // R3 directed
    run_op(2'd0, 2'd2, 64'hFFFF_7FFF_0000_8000, 64'h8000_0000_0000_7FFF);
    // R4 directed: negative -> 00, 256 -> FF, 255 stays
    run_op(2'd1, 2'd1, 64'h0080_00FF_0100_8000, 64'hFFFF_7FFF_0000_0001);
    // R5 / R6 all granularities
    for (int s = 0; s < 3; s++) begin
      run_op(2'd2, 2'(s), 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
      run_op(2'd3, 2'(s), 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
    end
    // R7 every rejected combination
    run_op(2'd0, 2'd0, '1, '1);
    run_op(2'd0, 2'd3, '1, '1);
    run_op(2'd1, 2'd0, '1, '1);
    run_op(2'd1, 2'd2, '1, '1);
    run_op(2'd1, 2'd3, '1, '1);
    run_op(2'd2, 2'd3, '1, '1);
    run_op(2'd3, 2'd3, '1, '1);

    for (int n = 0; n < 600; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      // bias some lanes toward clamp edges
      if (n % 4 == 0) a = a & 64'h80FF_80FF_80FF_80FF;
      if (n % 5 == 0) b = b | 64'h007F_007F_0000_7F00;
      run_op(2'($urandom), 2'($urandom), a, b);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule